// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block runs the descriptor list of one DMA channel. Once software has set a list base address, an initial consumer cycle state and the list enable, a doorbell that names the channel starts the walk. The walker reads the list one 32-bit word at a time through a request/response read port, and it accepts any response latency. For every data element it presents a transfer command to a data mover, made of a byte count, a 64-bit source address and a 64-bit destination address. It then waits for the mover's done strobe before it moves on to the next element.

Each element starts with a control word. Its cycle bit must match the walker's consumer cycle state. If it does not match, the walker has reached the end of the valid part of the list: it stops, reports a normal stop, and waits for another doorbell, which resumes from the same element. A link element sends the fetch pointer to a new 64-bit address, and it can also invert the consumer cycle state so that a ring buffer can be reused. When a descriptor read returns an error response, the walker stops with error status and raises an abort pulse.

Top module: `llist_walker`

## Requirements
- R1: After reset, status is 0 (never started), and rd_req, cmd_valid, evt_local, evt_remote and evt_abort are all low.
- R2: A doorbell (db_valid high with db_ch equal to the CH_ID parameter) starts the walk only while cfg_list_en is high and status is not 1. The first start after reset, and any start after an error, loads the fetch pointer from cfg_base and the cycle state from cfg_ccs. A doorbell for another channel, a doorbell while cfg_list_en is low, and a doorbell while running are all ignored.
- R3: Each descriptor word is requested with a one-cycle rd_req pulse. rd_addr is the element address plus 4 times the word index. No new request is made until rd_valid has returned for the previous one, and any latency of one cycle or more is accepted.
- R4: Control word bits are: bit 0 cycle, bit 1 toggle-cycle, bit 2 link, bit 3 local interrupt enable, bit 4 remote interrupt enable. If bit 0 differs from the consumer cycle state, the walker stops with status 3 and issues no command for that element.
- R5: A data element (bit 2 clear) is six words in this order: control, byte count, source low, source high, destination low, destination high. The walker then holds cmd_valid with those fields steady until cmd_done, and the next element is fetched 24 bytes further on.
- R6: A link element (bit 2 set) is three words: control, next address low, next address high. Fetching continues at that address, and the consumer cycle state is inverted when bit 1 is set.
- R7: status reads 1 from the cycle after an accepted doorbell until the walker stops, 3 after a cycle-bit stop, and 2 after an error. No read request or command is made while status is not 1.
- R8: A doorbell while status is 3 resumes at the element that caused the stop, using the current consumer cycle state.
- R9: When an element with bit 3 set completes (cmd_done), evt_local pulses for one cycle. When bit 4 is set, evt_remote pulses the same way.
- R10: A descriptor read answered with rd_err sets status 2, pulses evt_abort for one cycle, and issues no command for that element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 64 | List base byte address |
| cfg_ccs | input | 1 | Initial consumer cycle state |
| cfg_list_en | input | 1 | List mode enable; doorbells are ignored when low |
| db_valid | input | 1 | Doorbell strobe |
| db_ch | input | 3 | Channel number carried by the doorbell |
| rd_req | output | 1 | Descriptor word read request (one-cycle pulse) |
| rd_addr | output | 64 | Byte address of the requested word |
| rd_valid | input | 1 | Read response valid |
| rd_err | input | 1 | Read response carries an error |
| rd_data | input | 32 | Read response word |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_size | output | 32 | Transfer byte count |
| cmd_src | output | 64 | Transfer source address |
| cmd_dst | output | 64 | Transfer destination address |
| cmd_done | input | 1 | Mover has finished the command |
| status | output | 2 | 0 idle, 1 running, 2 error, 3 stopped |
| evt_local | output | 1 | Local done event pulse |
| evt_remote | output | 1 | Remote done event pulse |
| evt_abort | output | 1 | Abort pulse on a read error |

## Verification
The bench goes after the places where the cycle state and the fetch pointer can be lost. It covers a link that toggles the cycle state next to one that does not, a resume after a cycle-bit stop (a design that reloaded the base would replay finished elements), and a restart after an error (a design that resumed would skip the start of the list). A stale control word as the very first element must give no command. A read error in the middle of an element must abort before any command leaves. Doorbells for another channel, doorbells while running and doorbells with list mode off must leave the read count unchanged; a faulty decode would show up as extra reads or replayed commands. Read latency is varied across runs, so a walker that assumed a fixed latency would capture wrong words.

// File: rtl/llw_pkg.sv
package llw_pkg;
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_CMD} state_e;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ERR  = 2'd2,
        ST_STOP = 2'd3
    } stat_e;
    localparam int CTL_W      = 5;
    localparam int CTL_CYC    = 0;
    localparam int CTL_TGL    = 1;
    localparam int CTL_LNK    = 2;
    localparam int CTL_LIE    = 3;
    localparam int CTL_RIE    = 4;
    localparam int DATA_WORDS = 6;
    localparam int LINK_WORDS = 3;
endpackage

// File: rtl/llw_addr.sv
module llw_addr #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 3,
    parameter int NWORDS = 6,
    localparam int AW    = 2 * WORD_W,
    localparam int BYTES = WORD_W / 8
) (
    input  logic [AW-1:0]    ptr,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    word_addr,
    output logic [AW-1:0]    next_elem
);
    assign word_addr = ptr + AW'(idx) * AW'(BYTES);
    assign next_elem = ptr + AW'(NWORDS * BYTES);
endmodule

// File: rtl/llw_core.sv
module llw_core
    import llw_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CH_W   = 3,
    parameter int CH_ID  = 0,
    parameter int IDX_W  = 3,
    localparam int AW    = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_base,
    input  logic              cfg_ccs,
    input  logic              cfg_list_en,
    input  logic              db_valid,
    input  logic [CH_W-1:0]   db_ch,
    input  logic              rd_valid,
    input  logic              rd_err,
    input  logic [WORD_W-1:0] rd_data,
    input  logic [AW-1:0]     next_elem,
    input  logic              cmd_done,
    output logic [AW-1:0]     ptr,
    output logic [IDX_W-1:0]  idx,
    output logic              rd_req,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] cmd_size,
    output logic [AW-1:0]     cmd_src,
    output logic [AW-1:0]     cmd_dst,
    output logic [1:0]        status,
    output logic              evt_local,
    output logic              evt_remote,
    output logic              evt_abort
);
    typedef struct packed {
        state_e             st;
        stat_e              stat;
        logic [AW-1:0]      ptr;
        logic [IDX_W-1:0]   idx;
        logic               ccs;
        logic [CTL_W-1:0]   ctl;
        logic [WORD_W-1:0]  size;
        logic [AW-1:0]      src;
        logic [AW-1:0]      dst;
        logic               ev_l;
        logic               ev_r;
        logic               abort;
    } regs_t;

    regs_t r_q, r_d;
    logic  db_hit;

    assign db_hit = db_valid && (db_ch == CH_W'(CH_ID)) && cfg_list_en;

    always_comb begin
        r_d       = r_q;
        r_d.ev_l  = 1'b0;
        r_d.ev_r  = 1'b0;
        r_d.abort = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (db_hit) begin
                    r_d.st   = S_ISSUE;
                    r_d.stat = ST_RUN;
                    r_d.idx  = '0;
                    if (r_q.stat != ST_STOP) begin
                        r_d.ptr = cfg_base;
                        r_d.ccs = cfg_ccs;
                    end
                end
            end
            S_ISSUE: r_d.st = S_WAIT;
            S_WAIT: begin
                if (rd_valid) begin
                    if (rd_err) begin
                        r_d.st    = S_IDLE;
                        r_d.stat  = ST_ERR;
                        r_d.abort = 1'b1;
                    end else if (r_q.idx == '0) begin
                        if (rd_data[CTL_CYC] != r_q.ccs) begin
                            r_d.st   = S_IDLE;
                            r_d.stat = ST_STOP;
                        end else begin
                            r_d.ctl = rd_data[CTL_W-1:0];
                            r_d.idx = IDX_W'(1);
                            r_d.st  = S_ISSUE;
                        end
                    end else if (r_q.ctl[CTL_LNK]) begin
                        if (r_q.idx == IDX_W'(1)) begin
                            r_d.src[WORD_W-1:0] = rd_data;
                            r_d.idx = IDX_W'(2);
                        end else begin
                            r_d.ptr = {rd_data, r_q.src[WORD_W-1:0]};
                            r_d.ccs = r_q.ccs ^ r_q.ctl[CTL_TGL];
                            r_d.idx = '0;
                        end
                        r_d.st = S_ISSUE;
                    end else begin
                        case (r_q.idx)
                            IDX_W'(1): r_d.size              = rd_data;
                            IDX_W'(2): r_d.src[WORD_W-1:0]   = rd_data;
                            IDX_W'(3): r_d.src[AW-1:WORD_W]  = rd_data;
                            IDX_W'(4): r_d.dst[WORD_W-1:0]   = rd_data;
                            default:   r_d.dst[AW-1:WORD_W]  = rd_data;
                        endcase
                        if (r_q.idx == IDX_W'(DATA_WORDS - 1)) begin
                            r_d.st = S_CMD;
                        end else begin
                            r_d.idx = r_q.idx + IDX_W'(1);
                            r_d.st  = S_ISSUE;
                        end
                    end
                end
            end
            default: begin
                if (cmd_done) begin
                    r_d.ev_l = r_q.ctl[CTL_LIE];
                    r_d.ev_r = r_q.ctl[CTL_RIE];
                    r_d.ptr  = next_elem;
                    r_d.idx  = '0;
                    r_d.st   = S_ISSUE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ptr        = r_q.ptr;
    assign idx        = r_q.idx;
    assign rd_req     = (r_q.st == S_ISSUE);
    assign cmd_valid  = (r_q.st == S_CMD);
    assign cmd_size   = r_q.size;
    assign cmd_src    = r_q.src;
    assign cmd_dst    = r_q.dst;
    assign status     = r_q.stat;
    assign evt_local  = r_q.ev_l;
    assign evt_remote = r_q.ev_r;
    assign evt_abort  = r_q.abort;

    // R3: a read request lasts one cycle and the next waits for a response
    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R5: the command stays steady until the mover reports done
    a_r5_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_src)
                                      && $stable(cmd_dst) && $stable(cmd_size)));

    // R7: nothing is requested or commanded unless the walker is running
    a_r7_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'd1) |-> (!rd_req && !cmd_valid));

    // R10: an abort pulse comes with error status
    a_r10_abort_err: assert property (@(posedge clk) disable iff (!rst_n)
        evt_abort |-> (status == 2'd2));

    // R9: a done event only follows a completed command
    a_r9_evt_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_local || evt_remote) |-> $past(cmd_valid && cmd_done));
endmodule

// File: rtl/llist_walker.sv
module llist_walker #(
    parameter int WORD_W = 32,
    parameter int CH_W   = 3,
    parameter int CH_ID  = 0,
    localparam int AW    = 2 * WORD_W,
    localparam int IDX_W = $clog2(llw_pkg::DATA_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_base,
    input  logic              cfg_ccs,
    input  logic              cfg_list_en,
    input  logic              db_valid,
    input  logic [CH_W-1:0]   db_ch,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_valid,
    input  logic              rd_err,
    input  logic [WORD_W-1:0] rd_data,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] cmd_size,
    output logic [AW-1:0]     cmd_src,
    output logic [AW-1:0]     cmd_dst,
    input  logic              cmd_done,
    output logic [1:0]        status,
    output logic              evt_local,
    output logic              evt_remote,
    output logic              evt_abort
);
    logic [AW-1:0]    ptr;
    logic [IDX_W-1:0] idx;
    logic [AW-1:0]    next_elem;

    llw_addr #(.WORD_W(WORD_W), .IDX_W(IDX_W), .NWORDS(llw_pkg::DATA_WORDS)) u_addr (
        .ptr       (ptr),
        .idx       (idx),
        .word_addr (rd_addr),
        .next_elem (next_elem)
    );

    llw_core #(.WORD_W(WORD_W), .CH_W(CH_W), .CH_ID(CH_ID), .IDX_W(IDX_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_base    (cfg_base),
        .cfg_ccs     (cfg_ccs),
        .cfg_list_en (cfg_list_en),
        .db_valid    (db_valid),
        .db_ch       (db_ch),
        .rd_valid    (rd_valid),
        .rd_err      (rd_err),
        .rd_data     (rd_data),
        .next_elem   (next_elem),
        .cmd_done    (cmd_done),
        .ptr         (ptr),
        .idx         (idx),
        .rd_req      (rd_req),
        .cmd_valid   (cmd_valid),
        .cmd_size    (cmd_size),
        .cmd_src     (cmd_src),
        .cmd_dst     (cmd_dst),
        .status      (status),
        .evt_local   (evt_local),
        .evt_remote  (evt_remote),
        .evt_abort   (evt_abort)
    );
endmodule

// File: tb/llist_walker_test.sv
module llist_walker_test;
    localparam int CH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cfg_base = '0;
    logic        cfg_ccs = 1'b1;
    logic        cfg_list_en = 1'b1;
    logic        db_valid = 1'b0;
    logic [2:0]  db_ch = '0;
    logic        rd_req;
    logic [63:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic        rd_err = 1'b0;
    logic [31:0] rd_data = '0;
    logic        cmd_valid;
    logic [31:0] cmd_size;
    logic [63:0] cmd_src, cmd_dst;
    logic        cmd_done = 1'b0;
    logic [1:0]  status;
    logic        evt_local, evt_remote, evt_abort;

    always #2 clk = ~clk;

    llist_walker #(.CH_ID(CH)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_ccs(cfg_ccs),
        .cfg_list_en(cfg_list_en), .db_valid(db_valid), .db_ch(db_ch),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_err(rd_err),
        .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_size(cmd_size),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_done(cmd_done),
        .status(status), .evt_local(evt_local), .evt_remote(evt_remote),
        .evt_abort(evt_abort)
    );

    // {flags, size, src_lo, dst_lo}; the cycle bit is added when written
    localparam logic [31:0] VEC [4][4] = '{
        '{32'h00, 32'd40, 32'h1000, 32'h2000},
        '{32'h08, 32'd80, 32'h1100, 32'h2100},
        '{32'h00, 32'd12, 32'h1200, 32'h2200},
        '{32'h18, 32'd4,  32'h1300, 32'h2300}
    };

    logic [31:0] mem [256];
    int          lat = 3;
    logic [63:0] err_addr = '1;
    int          ntests = 0, nfail = 0, cycles = 0;
    int          nreads = 0, viol = 0, ncmd = 0, nloc = 0, nrem = 0, nabt = 0;
    logic [63:0] first_addr;
    logic [63:0] lsrc [16];
    logic [63:0] ldst [16];
    logic [31:0] lsz  [16];
    logic        pend = 1'b0, mbusy = 1'b0;
    int          rcnt = 0, mcnt = 0;
    logic [63:0] paddr = '0;

    // memory and mover models, driven away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            pend = 1'b0; rd_valid = 1'b0; rd_err = 1'b0; mbusy = 1'b0; cmd_done = 1'b0;
        end else begin
            if (rd_valid) begin rd_valid = 1'b0; rd_err = 1'b0; end
            if (pend) begin
                if (rcnt == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = mem[paddr[9:2]];
                    rd_err   = (paddr == err_addr);
                    pend     = 1'b0;
                end else rcnt--;
            end
            if (rd_req) begin
                if (pend) viol++;
                if (nreads == 0) first_addr = rd_addr;
                nreads++;
                pend = 1'b1; paddr = rd_addr; rcnt = lat;
            end
            if (cmd_done) begin
                cmd_done = 1'b0;
            end else if (cmd_valid && !mbusy) begin
                if (ncmd < 16) begin
                    lsrc[ncmd] = cmd_src; ldst[ncmd] = cmd_dst; lsz[ncmd] = cmd_size;
                end
                ncmd++; mbusy = 1'b1; mcnt = 2;
            end else if (mbusy) begin
                if (mcnt == 0) begin cmd_done = 1'b1; mbusy = 1'b0; end
                else mcnt--;
            end
            if (evt_local)  nloc++;
            if (evt_remote) nrem++;
            if (evt_abort)  nabt++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        @(negedge clk);
        nreads = 0; viol = 0; ncmd = 0; nloc = 0; nrem = 0; nabt = 0;
    endtask

    task automatic clr_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
    endtask

    task automatic put_data(input int a, input logic [31:0] ctl, input logic [31:0] sz,
                            input logic [63:0] s, input logic [63:0] d);
        mem[a/4]   = ctl;       mem[a/4+1] = sz;
        mem[a/4+2] = s[31:0];   mem[a/4+3] = s[63:32];
        mem[a/4+4] = d[31:0];   mem[a/4+5] = d[63:32];
    endtask

    task automatic put_link(input int a, input logic [31:0] ctl, input logic [63:0] nxt);
        mem[a/4] = ctl; mem[a/4+1] = nxt[31:0]; mem[a/4+2] = nxt[63:32];
    endtask

    task automatic ring(input int ch);
        @(negedge clk); db_valid = 1'b1; db_ch = 3'(ch);
        @(negedge clk); db_valid = 1'b0;
    endtask

    task automatic wait_stop();
        for (int i = 0; i < 4000 && status == 2'd1; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_table(input logic cyc);
        clr_mem();
        for (int i = 0; i < 4; i++)
            put_data(32'h100 + 24*i, VEC[i][0] | 32'(cyc), VEC[i][1],
                     {32'hA0 + 32'(i), VEC[i][2]}, {32'hB0 + 32'(i), VEC[i][3]});
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 150000) begin
            ntests++; nfail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 status", 64'(status), 64'd0);
        chk("R1 rd_req", 64'(rd_req), 64'd0);
        chk("R1 cmd_valid", 64'(cmd_valid), 64'd0);
        chk("R1 events", 64'({evt_local, evt_remote, evt_abort}), 64'd0);
        rst_n = 1'b1;

        // table walk: four data elements, then a stale control word
        lat = 3; cfg_ccs = 1'b1; cfg_base = 64'h100;
        load_table(1'b1);
        clr_counts();
        ring(CH);
        chk("R7 running", 64'(status), 64'd1);
        repeat (10) @(negedge clk);
        ring(CH);   // R2: doorbell while running ignored
        wait_stop();
        chk("R2 R5 command count", 64'(ncmd), 64'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R5 cmd size", 64'(lsz[i]), 64'(VEC[i][1]));
            chk("R5 cmd src", lsrc[i], {32'hA0 + 32'(i), VEC[i][2]});
            chk("R5 cmd dst", ldst[i], {32'hB0 + 32'(i), VEC[i][3]});
        end
        chk("R3 first address", first_addr, 64'h100);
        chk("R3 read count", 64'(nreads), 64'd25);
        chk("R3 one outstanding", 64'(viol), 64'd0);
        chk("R4 R7 stopped", 64'(status), 64'd3);
        chk("R9 local events", 64'(nloc), 64'd2);
        chk("R9 remote events", 64'(nrem), 64'd1);

        // R2: doorbell for another channel ignored
        clr_counts();
        ring(CH + 1);
        repeat (30) @(negedge clk);
        chk("R2 other channel reads", 64'(nreads), 64'd0);
        chk("R2 other channel status", 64'(status), 64'd3);

        // R8: resume at the element that stopped the walk
        put_data(32'h160, 32'h1, 32'd16, 64'hC0_0000_4000, 64'hD0_0000_5000);
        clr_counts();
        ring(CH);
        wait_stop();
        chk("R8 resume count", 64'(ncmd), 64'd1);
        chk("R8 resume src", lsrc[0], 64'hC0_0000_4000);
        chk("R8 resume first address", first_addr, 64'h160);
        chk("R8 stopped again", 64'(status), 64'd3);

        // R6: link with toggle, then link without toggle
        do_reset();
        chk("R1 status after reset", 64'(status), 64'd0);
        lat = 1; cfg_ccs = 1'b0; cfg_base = 64'h200;
        clr_mem();
        put_data(32'h200, 32'h0, 32'd8, 64'h11_0000_0010, 64'h21_0000_0020);
        put_link(32'h218, 32'h6, 64'h300);
        put_data(32'h300, 32'h1, 32'd8, 64'h12_0000_0030, 64'h22_0000_0040);
        put_link(32'h318, 32'h5, 64'h280);
        put_data(32'h280, 32'h1, 32'd8, 64'h13_0000_0050, 64'h23_0000_0060);
        clr_counts();
        ring(CH);
        wait_stop();
        chk("R6 link count", 64'(ncmd), 64'd3);
        chk("R6 before link", lsrc[0], 64'h11_0000_0010);
        chk("R6 toggled link", lsrc[1], 64'h12_0000_0030);
        chk("R6 plain link", lsrc[2], 64'h13_0000_0050);
        chk("R6 read count", 64'(nreads), 64'd25);
        chk("R4 R6 stop", 64'(status), 64'd3);

        // R10: error inside element 1, then restart from base
        do_reset();
        lat = 5; cfg_ccs = 1'b1; cfg_base = 64'h100;
        load_table(1'b1);
        err_addr = 64'h118 + 64'd8;
        clr_counts();
        ring(CH);
        wait_stop();
        repeat (8) @(negedge clk);
        chk("R10 commands before error", 64'(ncmd), 64'd1);
        chk("R10 abort pulses", 64'(nabt), 64'd1);
        chk("R10 error status", 64'(status), 64'd2);
        err_addr = '1;
        clr_counts();
        ring(CH);
        wait_stop();
        chk("R10 R2 restart count", 64'(ncmd), 64'd4);
        chk("R10 R2 restart src", lsrc[0], {32'hA0, VEC[0][2]});
        chk("R10 restart status", 64'(status), 64'd3);

        // R4: stale first element gives no command
        do_reset();
        lat = 2; clr_mem();
        clr_counts();
        ring(CH);
        wait_stop();
        chk("R4 stale first cmds", 64'(ncmd), 64'd0);
        chk("R4 stale first reads", 64'(nreads), 64'd1);
        chk("R4 stale first status", 64'(status), 64'd3);

        // R2: list mode off ignores the doorbell
        do_reset();
        cfg_list_en = 1'b0;
        load_table(1'b1);
        clr_counts();
        ring(CH);
        repeat (30) @(negedge clk);
        chk("R2 list off reads", 64'(nreads), 64'd0);
        chk("R2 list off status", 64'(status), 64'd0);

        summary();
    end
endmodule